// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block makes the keep-or-drop decision for each incoming Ethernet frame. For every frame it receives the 48-bit destination address, the frame length, the CRC and alignment error flags, a 6-bit multicast hash index that the CRC datapath computes, and a flag from buffer storage that says there is no room. One clock later it produces an accept pulse for buffer storage and an 8-bit receive status byte.

The decision depends on a configuration byte, a 6-byte station address and a 64-bit multicast hash filter. All of these are loaded through a simple byte-wide write port. Each term of the decision can be enabled on its own:

- unicast exact match against the station address
- broadcast acceptance
- multicast acceptance, gated by the hash filter
- promiscuous acceptance
- acceptance of short frames
- acceptance of errored frames
- monitor mode, which evaluates and reports every frame but never hands any frame to storage

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, res_valid, res_accept and res_status are 0. The configuration byte, the station address and the hash filter are all zero.
- R2: A write with wr_en=1 stores wr_data at the location given by wr_addr. Addresses 0..5 hold station byte k, and byte k is compared with destination bits [8k+7:8k]. Addresses 6..13 hold hash byte j, which covers filter bits [8j+7:8j]. Address 14 holds the configuration byte. Writes to address 15 change nothing.
- R3: Configuration bits are: bit 0 accept errored, bit 1 accept short, bit 2 accept broadcast, bit 3 accept multicast, bit 4 promiscuous, bit 5 monitor. A destination with bit 0 clear is unicast. A unicast frame passes the address test only when all 48 bits equal the station address, unless promiscuous mode is set.
- R4: The all-ones destination passes the address test only when bit 2 or bit 4 is set.
- R5: A destination with bit 0 set that is not all ones passes the address test when bit 3 is set and filter bit frm_hash_idx is 1, or when bit 4 is set.
- R6: When promiscuous mode is set, every destination passes the address test. The length rule and the error rule still apply.
- R7: A frame with frm_len below 64 fails unless bit 1 is set. A length of 64 is not short.
- R8: A frame with frm_crc_err or frm_align_err fails unless bit 0 is set.
- R9: When monitor mode is set, res_accept stays 0. res_valid and res_status still report the frame.
- R10: A frame that passes while buf_full=1 is not accepted, and status bit 4 (missed) is set. Missed is never set in monitor mode.
- R11: res_status holds the following bits: bit 0 = frame passed with no CRC or alignment error; bit 1 = CRC error; bit 2 = alignment error; bit 4 = missed; bit 5 = destination bit 0 (group address). Bits 3, 6 and 7 are 0. The status byte holds its value until the next frame.
- R12: res_valid pulses, together with res_accept and the new status, in the cycle after the one in which frm_valid is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| frm_valid | input | 1 | Frame descriptor valid for one cycle |
| frm_dest | input | 48 | Destination address; first octet in bits [7:0] |
| frm_len | input | 11 | Frame length in bytes |
| frm_crc_err | input | 1 | Frame failed its CRC check |
| frm_align_err | input | 1 | Frame has an alignment error |
| frm_hash_idx | input | 6 | Top six bits of the destination CRC |
| buf_full | input | 1 | Buffer storage has no room |
| res_valid | output | 1 | Decision pulse |
| res_accept | output | 1 | Frame is handed to buffer storage |
| res_status | output | 8 | Receive status byte |

## Verification
The bench sweeps all 64 configuration bytes against unicast hits, unicast misses, broadcast and multicast destinations. These run over lengths of 63 and 64, with no error, a CRC error and an alignment error, and with the buffer full and not full. The hash index walks through every filter bit.

The sweep targets the following mistakes:
- Treating broadcast as ordinary multicast would let the all-ones address through with only bit 3 set.
- An off-by-one length compare would reject 64-byte frames.
- A monitor mode that gates status instead of accept would lose the reported flags.
- A missing buffer-full gate would accept frames with no room and never raise the missed flag.

Separate checks cover the reset state, a write to the unused address, and status holding between frames.

// File: rtl/rx_filter_pkg.sv
package rx_filter_pkg;

    typedef struct packed {
        logic monitor;
        logic promisc;
        logic take_mcast;
        logic take_bcast;
        logic take_short;
        logic take_err;
    } rxf_cfg_t;

    localparam int ST_OK     = 0;
    localparam int ST_CRC    = 1;
    localparam int ST_ALIGN  = 2;
    localparam int ST_MISSED = 4;
    localparam int ST_GROUP  = 5;

endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
    import rx_filter_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BYTES = 8,
    parameter int AW         = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [7:0]              wr_data,
    output logic [ADDR_BYTES*8-1:0] station,
    output logic [HASH_BYTES*8-1:0] hash_tbl,
    output rxf_cfg_t                cfg
);
    localparam int CFG_ADDR = ADDR_BYTES + HASH_BYTES;

    typedef struct packed {
        logic [ADDR_BYTES*8-1:0] sta;
        logic [HASH_BYTES*8-1:0] hash;
        rxf_cfg_t                cfg;
    } regs_t;

    regs_t r_d, r_q;
    logic [1:0] unused_hi;
    assign unused_hi = wr_data[7:6];

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            for (int k = 0; k < ADDR_BYTES; k++) begin
                if (wr_addr == AW'(k)) r_d.sta[k*8 +: 8] = wr_data;
            end
            for (int j = 0; j < HASH_BYTES; j++) begin
                if (wr_addr == AW'(ADDR_BYTES + j)) r_d.hash[j*8 +: 8] = wr_data;
            end
            if (wr_addr == AW'(CFG_ADDR)) r_d.cfg = rxf_cfg_t'(wr_data[5:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign station  = r_q.sta;
    assign hash_tbl = r_q.hash;
    assign cfg      = r_q.cfg;

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == AW'(CFG_ADDR) |=> cfg == rxf_cfg_t'($past(wr_data[5:0]))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg) && $stable(station) && $stable(hash_tbl)); // R2

endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match #(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BYTES = 8,
    parameter int IDX_W      = $clog2(HASH_BYTES*8)
) (
    input  logic [ADDR_BYTES*8-1:0] dest,
    input  logic [ADDR_BYTES*8-1:0] station,
    input  logic [HASH_BYTES*8-1:0] hash_tbl,
    input  logic [IDX_W-1:0]        hash_idx,
    output logic                    is_group,
    output logic                    is_bcast,
    output logic                    sta_hit,
    output logic                    hash_hit
);
    logic [ADDR_BYTES-1:0] byte_eq;

    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_cmp
        assign byte_eq[k] = (dest[k*8 +: 8] == station[k*8 +: 8]);
    end

    always_comb begin
        is_group = dest[0];
        is_bcast = &dest;
        sta_hit  = &byte_eq;
        hash_hit = hash_tbl[hash_idx];
    end

endmodule

// File: rtl/rxf_verdict.sv
module rxf_verdict
    import rx_filter_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter int MIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rxf_cfg_t         cfg,
    input  logic             frm_valid,
    input  logic [LEN_W-1:0] frm_len,
    input  logic             crc_err,
    input  logic             align_err,
    input  logic             buf_full,
    input  logic             is_group,
    input  logic             is_bcast,
    input  logic             sta_hit,
    input  logic             hash_hit,
    output logic             res_valid,
    output logic             res_accept,
    output logic [7:0]       res_status
);
    typedef struct packed {
        logic       valid;
        logic       accept;
        logic [7:0] status;
    } out_t;

    out_t o_d, o_q;
    logic addr_ok, len_ok, err_ok, pass;

    always_comb begin
        addr_ok = cfg.promisc
                | (!is_group && sta_hit)
                | (is_bcast && cfg.take_bcast)
                | (is_group && !is_bcast && cfg.take_mcast && hash_hit);
        len_ok  = (frm_len >= LEN_W'(MIN_LEN)) | cfg.take_short;
        err_ok  = !(crc_err | align_err) | cfg.take_err;
        pass    = addr_ok & len_ok & err_ok;

        o_d        = o_q;
        o_d.valid  = frm_valid;
        o_d.accept = 1'b0;
        if (frm_valid) begin
            o_d.accept             = pass && !buf_full && !cfg.monitor;
            o_d.status             = '0;
            o_d.status[ST_OK]      = pass && !crc_err && !align_err;
            o_d.status[ST_CRC]     = crc_err;
            o_d.status[ST_ALIGN]   = align_err;
            o_d.status[ST_MISSED]  = pass && buf_full && !cfg.monitor;
            o_d.status[ST_GROUP]   = is_group;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign res_valid  = o_q.valid;
    assign res_accept = o_q.accept;
    assign res_status = o_q.status;

    AST_MON_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && cfg.monitor |=> !res_accept); // R9
    AST_ACC_NOT_MISSED: assert property (@(posedge clk) disable iff (!rst_n)
        res_accept |-> !res_status[ST_MISSED]); // R10
    AST_FULL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && buf_full |=> !res_accept); // R10
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        res_status[3] == 1'b0 && res_status[7:6] == 2'b00); // R11
    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        res_status[ST_OK] |-> !res_status[ST_CRC] && !res_status[ST_ALIGN]); // R11
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> res_valid); // R12
    AST_ACC_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_accept |-> res_valid); // R12

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rx_filter_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BYTES = 8,
    parameter int LEN_W      = 11,
    parameter int MIN_LEN    = 64,
    localparam int AW        = $clog2(ADDR_BYTES + HASH_BYTES + 2),
    localparam int IDX_W     = $clog2(HASH_BYTES*8)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [7:0]              wr_data,
    input  logic                    frm_valid,
    input  logic [ADDR_BYTES*8-1:0] frm_dest,
    input  logic [LEN_W-1:0]        frm_len,
    input  logic                    frm_crc_err,
    input  logic                    frm_align_err,
    input  logic [IDX_W-1:0]        frm_hash_idx,
    input  logic                    buf_full,
    output logic                    res_valid,
    output logic                    res_accept,
    output logic [7:0]              res_status
);
    logic [ADDR_BYTES*8-1:0] station;
    logic [HASH_BYTES*8-1:0] hash_tbl;
    rxf_cfg_t                cfg;
    logic is_group, is_bcast, sta_hit, hash_hit;

    rxf_regs #(.ADDR_BYTES(ADDR_BYTES), .HASH_BYTES(HASH_BYTES), .AW(AW)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .station(station), .hash_tbl(hash_tbl), .cfg(cfg)
    );

    rxf_addr_match #(.ADDR_BYTES(ADDR_BYTES), .HASH_BYTES(HASH_BYTES), .IDX_W(IDX_W)) i_match (
        .dest(frm_dest), .station(station), .hash_tbl(hash_tbl), .hash_idx(frm_hash_idx),
        .is_group(is_group), .is_bcast(is_bcast), .sta_hit(sta_hit), .hash_hit(hash_hit)
    );

    rxf_verdict #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) i_verdict (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .frm_valid(frm_valid), .frm_len(frm_len),
        .crc_err(frm_crc_err), .align_err(frm_align_err), .buf_full(buf_full),
        .is_group(is_group), .is_bcast(is_bcast), .sta_hit(sta_hit), .hash_hit(hash_hit),
        .res_valid(res_valid), .res_accept(res_accept), .res_status(res_status)
    );

    AST_GROUP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> res_status[ST_GROUP] == $past(frm_dest[0])); // R11

endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        frm_valid = 1'b0;
    logic [47:0] frm_dest = '0;
    logic [10:0] frm_len = '0;
    logic        frm_crc_err = 1'b0;
    logic        frm_align_err = 1'b0;
    logic [5:0]  frm_hash_idx = '0;
    logic        buf_full = 1'b0;
    logic        res_valid, res_accept;
    logic [7:0]  res_status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [47:0] sta_m = '0;
    logic [63:0] hash_m = '0;
    logic [5:0]  cfg_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_addr_filter i_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frm_valid(frm_valid), .frm_dest(frm_dest), .frm_len(frm_len),
        .frm_crc_err(frm_crc_err), .frm_align_err(frm_align_err),
        .frm_hash_idx(frm_hash_idx), .buf_full(buf_full),
        .res_valid(res_valid), .res_accept(res_accept), .res_status(res_status)
    );

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {valid,accept,status} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 4'd6) sta_m[a*8 +: 8] = d;
        else if (a < 4'd14) hash_m[(a-6)*8 +: 8] = d;
        else if (a == 4'd14) cfg_m = d[5:0];
    endtask

    task automatic frame(input logic [47:0] d, input int len, input bit crc, input bit aln,
                         input int hidx, input bit full, input string tag_in);
        bit grp, bc, aok, lok, eok, pass, missed, acc;
        logic [7:0] st;
        string tag;
        @(negedge clk);
        frm_valid = 1'b1; frm_dest = d; frm_len = 11'(len);
        frm_crc_err = crc; frm_align_err = aln; frm_hash_idx = 6'(hidx); buf_full = full;
        @(posedge clk);
        @(negedge clk);
        frm_valid = 1'b0;
        grp  = d[0];
        bc   = (d == 48'hFFFF_FFFF_FFFF);
        aok  = cfg_m[4] || (!grp && d == sta_m) || (bc && cfg_m[2])
            || (grp && !bc && cfg_m[3] && hash_m[hidx]);
        lok  = (len >= 64) || cfg_m[1];
        eok  = !(crc || aln) || cfg_m[0];
        pass = aok && lok && eok;
        missed = pass && full && !cfg_m[5];
        acc    = pass && !full && !cfg_m[5];
        st = {2'b00, grp, missed, 1'b0, aln, crc, pass && !crc && !aln};
        tag = tag_in;
        if (tag == "") begin
            if (cfg_m[5]) tag = "R9";
            else if (full) tag = "R10";
            else if (crc || aln) tag = "R8";
            else if (len < 64) tag = "R7";
            else if (cfg_m[4]) tag = "R6";
            else if (bc) tag = "R4";
            else if (grp) tag = "R5";
            else tag = "R3";
        end
        check(tag, {res_valid, res_accept, res_status}, {1'b1, acc, st});
    endtask

    initial begin
        int n;
        logic [47:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs clear under reset
        check("R1", {res_valid, res_accept, res_status}, 10'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {res_valid, res_accept, res_status}, 10'b0);
        // R1: station resets to zero, so destination 0 matches
        frame(48'h0, 64, 0, 0, 0, 0, "R1");

        for (int k = 0; k < 6; k++) wr(4'(k), 8'(8'h12 + k*8'h22) & 8'hFE);
        for (int j = 0; j < 8; j++) wr(4'(6 + j), 8'(8'hA5 ^ (j*8'h3C)));

        // R2: address 15 ignored; broadcast stays rejected with config zero
        wr(4'd15, 8'hFF);
        frame(48'hFFFF_FFFF_FFFF, 64, 0, 0, 0, 0, "R2");
        // R11, R12: status holds, valid drops in the cycle after the pulse
        frame(sta_m | 48'h1, 64, 1, 0, 3, 0, "R12");
        @(negedge clk);
        check("R11", {res_valid, res_accept, res_status}, {2'b00, 8'h22});

        n = 0;
        for (int c = 0; c < 64; c++) begin
            wr(4'd14, 8'(c));
            for (int cls = 0; cls < 4; cls++)
                for (int lk = 0; lk < 2; lk++)
                    for (int e = 0; e < 3; e++)
                        for (int f = 0; f < 2; f++) begin
                            case (cls)
                                0: d = sta_m;
                                1: d = sta_m ^ (48'h10 << ((n % 6) * 8));
                                2: d = 48'hFFFF_FFFF_FFFF;
                                default: d = {sta_m[47:8] ^ 40'(n * 977), 8'h01 ^ 8'(n << 1)};
                            endcase
                            frame(d, 63 + lk, e == 1, e == 2, (n * 7) % 64, f == 1, "");
                            n++;
                        end
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule